// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Matcher

This block sits behind a CAN protocol engine and takes each completely received frame: identifier, extended-format flag, remote flag, length code and eight data bytes. In one clock cycle it compares the frame against every mailbox set up for reception. Each mailbox has its own acceptance mask. The lowest-numbered mailbox that matches receives the frame. The block stores the payload and a timestamp in that mailbox and raises the pending flags. It records an overrun when software has not yet collected the previous message.

A compact register port lets software set up each mailbox and read back what was stored. The same port reads the three flag vectors and clears them by writing ones. Software can mask the receive interrupt per mailbox. A remote frame that lands in a mailbox with auto-answer enabled produces a one-cycle transmit request carrying the mailbox index.

Top module: `can_rx_mbox_match`

## Requirements
- R1: A mailbox takes part in matching only when its mode field equals 3'b001. It matches a frame when its stored extended flag equals the frame's. All 29 identifier bits must also agree, except the bits whose mask bit is 1, which are ignored. A frame matching no mailbox changes no flag.
- R2: When several mailboxes match, only the lowest-numbered one is affected, even if its pending flag is already set.
- R3: Storing a frame latches the length code and `timestamp_i` into the mailbox. For data frames it also latches all 64 data bits, with byte 0 in bits 7:0. Mailbox field 3 reads {12'b0, dlc[3:0], ts[15:0]}, field 4 reads data bits 31:0 and field 5 reads data bits 63:32.
- R4: A matched data frame sets the mailbox's bit in the pending vector (global register 0) in the clock edge that accepts it.
- R5: A matched remote frame sets the mailbox's bit in both the pending vector and the remote-pending vector (global register 1). It leaves the stored data bits unchanged.
- R6: A frame arriving while the mailbox's pending bit is set is written over the old contents when control bit 3 (keep-old) is 0. The mailbox's unread-overrun bit (global register 2) is set.
- R7: With keep-old set, such a frame is dropped and the stored length, data and timestamp stay unchanged. The unread-overrun bit is still set.
- R8: A remote frame stored in a mailbox whose control bit 4 (auto-answer) is 1 drives `tx_req_o` high for exactly the next cycle, with `tx_req_mb_o` holding the mailbox index. Nothing is requested otherwise.
- R9: Writing ones to global registers 0, 1 or 2 clears those bits. A flag set by a frame in the same cycle as its clear stays set.
- R10: `irq_o` is high exactly when some pending bit is 1 and its bit in the interrupt mask (global register 3, 1 = masked) is 0.
- R11: After reset all flag vectors are 0, the interrupt mask is all ones, every mailbox field reads 0 and `irq_o` and `tx_req_o` are 0.
- R12: Address bit ADDR_W-1 = 0 selects global register addr[1:0]. Otherwise addr[IDX_W+2:3] selects the mailbox and addr[2:0] the field. Field 0 is {ide, rtr, 1'b0, id[28:0]}, field 1 is the mask in bits 28:0, and field 2 is {auto-answer, keep-old, mode[2:0]} in bits 4:0. Fields 0-2 and register 3 are read/write; reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | One-cycle strobe: a complete frame is on the rx inputs |
| rx_id_i | input | 29 | Received identifier |
| rx_ide_i | input | 1 | Frame uses the extended identifier format |
| rx_rtr_i | input | 1 | Frame is a remote frame |
| rx_dlc_i | input | 4 | Length code |
| rx_data_i | input | 64 | Data bytes, byte 0 in bits 7:0 |
| timestamp_i | input | TS_W | Current time, latched on store |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_addr_i | input | ADDR_W | Register address |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rdata_o | output | 32 | Read data for cpu_addr_i |
| irq_o | output | 1 | Receive interrupt |
| tx_req_o | output | 1 | Auto-answer transmit request pulse |
| tx_req_mb_o | output | IDX_W | Mailbox index of the request |

## Verification
The bench builds the block with NUM_MB = 8 and TS_W = 16. This gives a 7-bit address and makes the highest mailbox index and the top bit of every flag vector easy to reach. With eight mailboxes, the tests can set up overlapping matches, a mailbox in a non-receive mode and masked and unmasked identifier bits, all at once. The bench then follows the frame into the one mailbox that should take it. The same-cycle clear-versus-set case and the drop path with keep-old are driven on purpose.

// File: rtl/can_rx_mbox_match.sv
module can_rx_mbox_match #(
  parameter int NUM_MB = 32,
  parameter int TS_W = 16,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid_i,
  input  logic [28:0]       rx_id_i,
  input  logic              rx_ide_i,
  input  logic              rx_rtr_i,
  input  logic [3:0]        rx_dlc_i,
  input  logic [63:0]       rx_data_i,
  input  logic [TS_W-1:0]   timestamp_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [31:0]       cpu_wdata_i,
  output logic [31:0]       cpu_rdata_o,
  output logic              irq_o,
  output logic              tx_req_o,
  output logic [IDX_W-1:0]  tx_req_mb_o
);
  localparam logic [2:0] MODE_RX = 3'b001;

  logic [28:0]     id_q   [NUM_MB];
  logic [28:0]     mask_q [NUM_MB];
  logic            ide_q  [NUM_MB];
  logic            rtr_q  [NUM_MB];
  logic [2:0]      mode_q [NUM_MB];
  logic            keep_q [NUM_MB];
  logic            ans_q  [NUM_MB];
  logic [3:0]      dlc_q  [NUM_MB];
  logic [63:0]     data_q [NUM_MB];
  logic [TS_W-1:0] ts_q   [NUM_MB];

  logic [NUM_MB-1:0] pend_q, rpend_q, unread_q, imask_q;
  logic [NUM_MB-1:0] hit, win_oh;
  logic [IDX_W-1:0]  win_idx;
  logic              win_any;

  always_comb begin
    for (int k = 0; k < NUM_MB; k++)
      hit[k] = (mode_q[k] == MODE_RX) && (ide_q[k] == rx_ide_i) &&
               (((id_q[k] ^ rx_id_i) & ~mask_q[k]) == 29'd0);
  end

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    for (int k = NUM_MB - 1; k >= 0; k--)
      if (hit[k]) begin
        win_any = 1'b1;
        win_idx = IDX_W'(k);
      end
  end

  wire accept = rx_valid_i && win_any;
  wire full   = pend_q[win_idx];
  wire store  = accept && !(full && keep_q[win_idx]);
  assign win_oh = NUM_MB'(1) << win_idx;

  wire             glb_sel = !cpu_addr_i[ADDR_W-1];
  wire [1:0]       glb_reg = cpu_addr_i[1:0];
  wire [IDX_W-1:0] mb_idx  = cpu_addr_i[IDX_W+2:3];
  wire [2:0]       fld     = cpu_addr_i[2:0];
  wire             mb_ok   = ({1'b0, mb_idx} < (IDX_W + 1)'(NUM_MB));
  wire [NUM_MB-1:0] wbits  = cpu_wdata_i[NUM_MB-1:0];

  wire [NUM_MB-1:0] clr_pend   = (cpu_we_i && glb_sel && glb_reg == 2'd0) ? wbits : '0;
  wire [NUM_MB-1:0] clr_rpend  = (cpu_we_i && glb_sel && glb_reg == 2'd1) ? wbits : '0;
  wire [NUM_MB-1:0] clr_unread = (cpu_we_i && glb_sel && glb_reg == 2'd2) ? wbits : '0;
  wire [NUM_MB-1:0] set_pend   = accept ? win_oh : '0;
  wire [NUM_MB-1:0] set_rpend  = (store && rx_rtr_i) ? win_oh : '0;
  wire [NUM_MB-1:0] set_unread = (accept && full) ? win_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      rpend_q  <= '0;
      unread_q <= '0;
      imask_q  <= '1;
      tx_req_o <= 1'b0;
      tx_req_mb_o <= '0;
    end else begin
      pend_q   <= (pend_q & ~clr_pend) | set_pend;
      rpend_q  <= (rpend_q & ~clr_rpend) | set_rpend;
      unread_q <= (unread_q & ~clr_unread) | set_unread;
      if (cpu_we_i && glb_sel && glb_reg == 2'd3) imask_q <= wbits;
      tx_req_o <= store && rx_rtr_i && ans_q[win_idx];
      tx_req_mb_o <= win_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_MB; k++) begin
        id_q[k] <= '0; mask_q[k] <= '0; ide_q[k] <= 1'b0; rtr_q[k] <= 1'b0;
        mode_q[k] <= '0; keep_q[k] <= 1'b0; ans_q[k] <= 1'b0;
        dlc_q[k] <= '0; data_q[k] <= '0; ts_q[k] <= '0;
      end
    end else begin
      if (cpu_we_i && !glb_sel && mb_ok) begin
        case (fld)
          3'd0: begin
            ide_q[mb_idx] <= cpu_wdata_i[31];
            rtr_q[mb_idx] <= cpu_wdata_i[30];
            id_q[mb_idx]  <= cpu_wdata_i[28:0];
          end
          3'd1: mask_q[mb_idx] <= cpu_wdata_i[28:0];
          3'd2: begin
            ans_q[mb_idx]  <= cpu_wdata_i[4];
            keep_q[mb_idx] <= cpu_wdata_i[3];
            mode_q[mb_idx] <= cpu_wdata_i[2:0];
          end
          default: ;
        endcase
      end
      if (store) begin
        dlc_q[win_idx] <= rx_dlc_i;
        ts_q[win_idx]  <= timestamp_i;
        if (!rx_rtr_i) data_q[win_idx] <= rx_data_i;
      end
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    if (glb_sel) begin
      case (glb_reg)
        2'd0: cpu_rdata_o = 32'(pend_q);
        2'd1: cpu_rdata_o = 32'(rpend_q);
        2'd2: cpu_rdata_o = 32'(unread_q);
        default: cpu_rdata_o = 32'(imask_q);
      endcase
    end else if (mb_ok) begin
      case (fld)
        3'd0: cpu_rdata_o = {ide_q[mb_idx], rtr_q[mb_idx], 1'b0, id_q[mb_idx]};
        3'd1: cpu_rdata_o = {3'b0, mask_q[mb_idx]};
        3'd2: cpu_rdata_o = {27'b0, ans_q[mb_idx], keep_q[mb_idx], mode_q[mb_idx]};
        3'd3: cpu_rdata_o = {12'b0, dlc_q[mb_idx], 16'(ts_q[mb_idx])};
        3'd4: cpu_rdata_o = data_q[mb_idx][31:0];
        3'd5: cpu_rdata_o = data_q[mb_idx][63:32];
        default: cpu_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(pend_q & ~imask_q);

  // R4 / R9: an accepted frame always leaves its pending bit set
  p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pend_q[$past(win_idx)]) else $error("pending bit not set");

  // R9: a clear with no competing set takes effect
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we_i && glb_sel && glb_reg == 2'd0 && cpu_wdata_i[0] && !(accept && win_idx == '0))
      |=> !pend_q[0]) else $error("pending bit 0 not cleared");

  // R6 / R7: overrun recorded
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && full) |=> unread_q[$past(win_idx)]) else $error("overrun not recorded");

  // R7: dropped frame leaves timestamp untouched
  p_keep_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && full && keep_q[win_idx]) |=> ts_q[$past(win_idx)] == $past(ts_q[win_idx]))
    else $error("kept mailbox was overwritten");

  // R8: requests only follow a remote frame
  p_tx_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> $past(rx_valid_i && rx_rtr_i)) else $error("spurious transmit request");

  // R1: unmatched frames leave flags alone
  p_no_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !win_any && !cpu_we_i) |=> ($stable(pend_q) && $stable(unread_q) && $stable(rpend_q)))
    else $error("flags moved without a match");
endmodule

// File: tb/can_rx_mbox_match_tb_top.sv
`timescale 1ns/1ps
module can_rx_mbox_match_tb_top;
  localparam int NMB = 8;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_ide = 0, rx_rtr = 0;
  logic [28:0] rx_id = '0;
  logic [3:0] rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [15:0] ts = '0;
  logic we = 0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, txr;
  logic [2:0] txmb;
  int total = 0, bad = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  can_rx_mbox_match #(.NUM_MB(NMB), .TS_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_id_i(rx_id), .rx_ide_i(rx_ide),
    .rx_rtr_i(rx_rtr), .rx_dlc_i(rx_dlc), .rx_data_i(rx_data), .timestamp_i(ts),
    .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .irq_o(irq), .tx_req_o(txr), .tx_req_mb_o(txmb));

  function automatic logic [6:0] mba(input int idx, input int f);
    return {1'b1, 3'(idx), 3'(f)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk); @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic frame(input logic [28:0] id, input logic ide, input logic rtr,
                       input logic [3:0] dlc, input logic [63:0] data, input logic [15:0] t);
    rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = dlc; rx_data = data; ts = t;
    rx_valid = 1;
    @(posedge clk); @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic clear_all();
    wr(7'h00, 32'hFF); wr(7'h01, 32'hFF); wr(7'h02, 32'hFF);
  endtask

  task automatic t_reset();
    rd(7'h00, v); chk("R11 pending", v, 0);
    rd(7'h01, v); chk("R11 remote", v, 0);
    rd(7'h02, v); chk("R11 unread", v, 0);
    rd(7'h03, v); chk("R11 imask", v, 32'hFF);
    rd(mba(3, 2), v); chk("R11 mode", v, 0);
    chk("R11 irq", irq, 0);
    chk("R11 txreq", txr, 0);
  endtask

  task automatic t_match();
    wr(mba(1, 0), {1'b1, 1'b0, 1'b0, 29'h0ABCD000});
    wr(mba(1, 1), 32'h0000_0FFF);
    wr(mba(1, 2), 32'h1);
    wr(mba(3, 0), {3'b000, 29'h00000055});
    wr(mba(3, 2), 32'h2);
    rd(mba(1, 0), v); chk("R12 id readback", v, {3'b100, 29'h0ABCD000});
    frame(29'h0ABCD5A5, 1, 0, 4'd1, 64'h1, 16'h0010);
    rd(7'h00, v); chk("R1 masked bits ignored", v, 32'h02);
    clear_all();
    frame(29'h0ABCE000, 1, 0, 4'd1, 64'h1, 16'h0011);
    rd(7'h00, v); chk("R1 unmasked bit differs", v, 0);
    frame(29'h0ABCD000, 0, 0, 4'd1, 64'h1, 16'h0012);
    rd(7'h00, v); chk("R1 ide mismatch", v, 0);
    frame(29'h00000055, 0, 0, 4'd1, 64'h1, 16'h0013);
    rd(7'h00, v); chk("R1 non-receive mode", v, 0);
  endtask

  task automatic t_priority();
    wr(mba(4, 0), {3'b000, 29'h00480000}); wr(mba(4, 2), 32'h1);
    wr(mba(6, 0), {3'b000, 29'h00480000}); wr(mba(6, 2), 32'h1);
    frame(29'h00480000, 0, 0, 4'd2, 64'h2, 16'h0020);
    rd(7'h00, v); chk("R2 lowest wins", v, 32'h10);
    frame(29'h00480000, 0, 0, 4'd2, 64'h2, 16'h0021);
    rd(7'h00, v); chk("R2 stays lowest when full", v, 32'h10);
    rd(7'h02, v); chk("R2 overrun on lowest", v, 32'h10);
    clear_all();
  endtask

  task automatic t_store();
    frame(29'h0ABCD001, 1, 0, 4'd5, 64'h1122334455667788, 16'h1234);
    rd(mba(1, 3), v); chk("R3 dlc and ts", v, 32'h0005_1234);
    rd(mba(1, 4), v); chk("R3 data low", v, 32'h55667788);
    rd(mba(1, 5), v); chk("R3 data high", v, 32'h11223344);
    rd(7'h00, v); chk("R4 pending", v, 32'h02);
    rd(7'h01, v); chk("R4 no remote flag", v, 0);
    clear_all();
  endtask

  task automatic t_remote();
    frame(29'h0ABCD002, 1, 1, 4'd3, 64'hDEADBEEFDEADBEEF, 16'h2222);
    chk("R8 no request without auto-answer", txr, 0);
    rd(7'h00, v); chk("R5 pending", v, 32'h02);
    rd(7'h01, v); chk("R5 remote pending", v, 32'h02);
    rd(mba(1, 4), v); chk("R5 data kept", v, 32'h55667788);
    rd(mba(1, 3), v); chk("R5 dlc updated", v, 32'h0003_2222);
    clear_all();
    wr(mba(1, 2), 32'h11);
    frame(29'h0ABCD003, 1, 1, 4'd0, 64'h0, 16'h2223);
    chk("R8 request", txr, 1);
    chk("R8 request index", txmb, 3'd1);
    @(posedge clk); @(negedge clk);
    chk("R8 single pulse", txr, 0);
    wr(mba(1, 2), 32'h1);
    clear_all();
  endtask

  task automatic t_overrun();
    frame(29'h0ABCD004, 1, 0, 4'd8, 64'h00000000AAAAAAAA, 16'h3000);
    frame(29'h0ABCD005, 1, 0, 4'd7, 64'h00000000CCCCCCCC, 16'h3333);
    rd(mba(1, 4), v); chk("R6 overwritten data", v, 32'hCCCCCCCC);
    rd(mba(1, 3), v); chk("R6 overwritten ts", v, 32'h0007_3333);
    rd(7'h02, v); chk("R6 unread set", v, 32'h02);
    wr(7'h02, 32'hFF);
    wr(mba(1, 2), 32'h09);
    frame(29'h0ABCD006, 1, 0, 4'd2, 64'h00000000BBBBBBBB, 16'h4444);
    rd(mba(1, 4), v); chk("R7 data kept", v, 32'hCCCCCCCC);
    rd(mba(1, 3), v); chk("R7 dlc and ts kept", v, 32'h0007_3333);
    rd(7'h02, v); chk("R7 unread set", v, 32'h02);
    rd(7'h00, v); chk("R7 pending still set", v, 32'h02);
    wr(mba(1, 2), 32'h1);
    clear_all();
  endtask

  task automatic t_clear();
    frame(29'h0ABCD007, 1, 0, 4'd1, 64'h0, 16'h5000);
    frame(29'h00480000, 0, 0, 4'd1, 64'h0, 16'h5001);
    wr(7'h00, 32'h02);
    rd(7'h00, v); chk("R9 w1c clears only bit 1", v, 32'h10);
    rx_id = 29'h00480000; rx_ide = 0; rx_rtr = 0; rx_valid = 1;
    addr = 7'h00; wdata = 32'h10; we = 1;
    @(posedge clk); @(negedge clk);
    rx_valid = 0; we = 0;
    rd(7'h00, v); chk("R9 set wins over clear", v, 32'h10);
  endtask

  task automatic t_irq();
    chk("R10 masked", irq, 0);
    wr(7'h03, 32'hEF);
    rd(7'h03, v); chk("R12 mask readback", v, 32'hEF);
    chk("R10 unmasked raises", irq, 1);
    wr(7'h00, 32'hFF);
    chk("R10 drops after clear", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_match();
    t_priority();
    t_store();
    t_remote();
    t_overrun();
    t_clear();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule